// File: doc/BRIEF.md
# Temperature-Adaptive Refresh Scheduler

This block paces auto-refresh requests towards a DRAM command sequencer. A down-counting interval timer expires at a fixed spacing, and every expiry adds one owed refresh to a pending counter. The request line stays high while anything is owed, and every acknowledge from the sequencer pays one back. Because the requests are spaced evenly, the supply current never sees a burst of back-to-back refreshes. The whole array is still covered once per retention window.

An on-die sensor delivers a small unsigned temperature code with a valid strobe. Two threshold inputs split the code range into three bands. In the cold band the retention window is 128 ms and the spacing is about 15.6 µs. In the nominal band the window is 64 ms and the spacing is 7.8 µs. In the hot band the window is 32 ms and the spacing is about 3.9 µs. The three reload values are derived from the clock-frequency parameter when the design is elaborated. A new band only takes hold when the running interval expires. Until the first valid sample arrives, the scheduler runs at the hot rate.

The pending counter is a three-state machine. `P_IDLE` moves to `P_BUSY` on an expiry. `P_BUSY` moves back to `P_IDLE` when the last owed refresh is acknowledged. `P_BUSY` moves to `P_FULL` when an expiry brings the count to the ceiling. `P_FULL` moves back to `P_BUSY` on an acknowledge. In `P_FULL`, an expiry that arrives without an acknowledge sets a sticky starvation flag. A separate counter of accepted acknowledges pulses once per full window of refreshes.

Top module: `refresh_sched`

## Requirements
- R1: Reset state: `ref_req_o`=0, `ovf_o`=0, `win_done_o`=0, and `rate_o`=2'b10 (hot). The rate code is 2'b00 for cold, 2'b01 for nominal and 2'b10 for hot.
- R2: Before any `temp_vld_i` strobe, requests are spaced by the hot interval of NOM/2 cycles, and `rate_o` reads 2'b10.
- R3: A temperature code is taken only in a cycle with `temp_vld_i`=1. A code below `thr_cold_i` selects cold. A code at or above `thr_hot_i` selects hot. Any other code selects nominal.
- R4: The interval is 2*NOM cycles in the cold band, NOM cycles in the nominal band and NOM/2 cycles in the hot band, where NOM = CLK_MHZ*NOM_NS/1000.
- R5: A newly sampled band does not change the running interval. It takes effect at the next expiry, and `rate_o` changes only in the cycle after an expiry.
- R6: Every expiry adds one to the pending count. `ref_req_o` is high exactly when the count is nonzero, and it rises in the cycle after the expiry.
- R7: An acknowledge is accepted only while `ref_req_o`=1, and each accepted acknowledge removes one pending refresh. An acknowledge while `ref_req_o`=0 has no effect on the count, the request or the window count.
- R8: The pending count saturates at PEND_MAX (8). An expiry at that count with no acknowledge in the same cycle sets `ovf_o`, which stays set until reset.
- R9: `win_done_o` pulses for one cycle, in the cycle after every WINDOW_REFS-th accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | TEMP_W | Temperature code from the sensor |
| temp_vld_i | input | 1 | Temperature code valid strobe |
| thr_cold_i | input | TEMP_W | Codes below this are cold |
| thr_hot_i | input | TEMP_W | Codes at or above this are hot |
| ref_ack_i | input | 1 | Sequencer accepted one refresh |
| ref_req_o | output | 1 | At least one refresh is owed |
| rate_o | output | 2 | Band currently pacing the timer |
| ovf_o | output | 1 | Sticky starvation flag |
| win_done_o | output | 1 | One-cycle pulse per full window of refreshes |

## Verification
Every temperature code from the lowest to the highest is swept against a fixed pair of thresholds. For each code the bench checks the reported band and the measured spacing between request rises. This separates comparisons that are off by one at either threshold and reload values that were derived wrongly. Each strobe is placed just after an expiry, so a band that is applied too early shows up before the next boundary. A starvation run stops acknowledging, checks the exact cycle at which the flag rises, and then drains the counter to expose a wrong ceiling. A stray acknowledge while idle is checked for underflow. The window pulse is compared against the bench's own count of the acknowledges that were accepted.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        BAND_COLD = 2'b00,
        BAND_NOM  = 2'b01,
        BAND_HOT  = 2'b10
    } band_e;

    typedef enum logic [1:0] {
        P_IDLE = 2'b00,
        P_BUSY = 2'b01,
        P_FULL = 2'b10
    } pend_state_e;

endpackage

// File: rtl/rs_band_sel.sv
module rs_band_sel
    import refresh_pkg::*;
#(
    parameter int TEMP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_vld_i,
    input  logic [TEMP_W-1:0] thr_cold_i,
    input  logic [TEMP_W-1:0] thr_hot_i,
    output band_e             band_o
);

    band_e band_q;
    band_e band_class;

    // Hot takes priority when the thresholds overlap.
    always_comb begin
        if (temp_i >= thr_hot_i) begin
            band_class = BAND_HOT;
        end else if (temp_i < thr_cold_i) begin
            band_class = BAND_COLD;
        end else begin
            band_class = BAND_NOM;
        end
    end

    // Starts hot, which is the safest rate, until the first valid sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= BAND_HOT;
        end else if (temp_vld_i) begin
            band_q <= band_class;
        end
    end

    assign band_o = band_q;

endmodule

// File: rtl/rs_interval_timer.sv
module rs_interval_timer
    import refresh_pkg::*;
#(
    parameter int HOT_CYC  = 4,
    parameter int NOM_CYC  = 8,
    parameter int COLD_CYC = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  band_e band_next_i,
    output logic  tick_o,
    output band_e band_act_o
);

    localparam int CW = $clog2(COLD_CYC + 1);
    localparam logic [CW-1:0] HOT_LD  = CW'(HOT_CYC - 1);
    localparam logic [CW-1:0] NOM_LD  = CW'(NOM_CYC - 1);
    localparam logic [CW-1:0] COLD_LD = CW'(COLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;
    band_e         band_act_q;

    always_comb begin
        unique case (band_next_i)
            BAND_COLD: reload = COLD_LD;
            BAND_NOM:  reload = NOM_LD;
            BAND_HOT:  reload = HOT_LD;
            default:   reload = HOT_LD;
        endcase
    end

    assign tick_o = (cnt_q == '0);

    // The band is only picked up at a boundary, so a running count is never cut.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= HOT_LD;
            band_act_q <= BAND_HOT;
        end else if (tick_o) begin
            cnt_q      <= reload;
            band_act_q <= band_next_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign band_act_o = band_act_q;

endmodule

// File: rtl/rs_pending.sv
module rs_pending
    import refresh_pkg::*;
#(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    output logic req_o,
    output logic accept_o,
    output logic ovf_o
);

    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] TOP  = PW'(PEND_MAX);
    localparam logic [PW-1:0] NEAR = PW'(PEND_MAX - 1);

    pend_state_e state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic          ovf_q;
    logic          dec;

    assign dec = ack_i && (state_q != P_IDLE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (tick_i && !dec && (state_q == P_FULL)) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Next state and count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            P_IDLE: begin
                if (tick_i) begin
                    state_d = P_BUSY;
                    cnt_d   = PW'(1);
                end
            end
            P_BUSY: begin
                if (tick_i && !dec) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == NEAR) begin
                        state_d = P_FULL;
                    end
                end else if (dec && !tick_i) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == PW'(1)) begin
                        state_d = P_IDLE;
                    end
                end
            end
            P_FULL: begin
                cnt_d = TOP;
                if (dec && !tick_i) begin
                    state_d = P_BUSY;
                    cnt_d   = NEAR;
                end
            end
            default: begin
                state_d = P_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        req_o    = (state_q != P_IDLE);
        accept_o = dec;
        ovf_o    = ovf_q;
    end

endmodule

// File: rtl/rs_window_cnt.sv
module rs_window_cnt #(
    parameter int WINDOW_REFS = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic win_done_o
);

    localparam int WW = $clog2(WINDOW_REFS);
    localparam logic [WW-1:0] LAST = WW'(WINDOW_REFS - 1);

    logic [WW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_i) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign win_done_o = done_q;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int NOM_NS      = 7800,
    parameter int TEMP_W      = 4,
    parameter int PEND_MAX    = 8,
    parameter int WINDOW_REFS = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              temp_vld_i,
    input  logic [TEMP_W-1:0] thr_cold_i,
    input  logic [TEMP_W-1:0] thr_hot_i,
    input  logic              ref_ack_i,
    output logic              ref_req_o,
    output logic [1:0]        rate_o,
    output logic              ovf_o,
    output logic              win_done_o
);

    localparam int NOM_CYC  = (CLK_MHZ * NOM_NS) / 1000;
    localparam int HOT_CYC  = NOM_CYC / 2;
    localparam int COLD_CYC = NOM_CYC * 2;

    band_e band_smp;
    band_e band_act;
    logic  tick;
    logic  accept;

    rs_band_sel #(
        .TEMP_W (TEMP_W)
    ) u_band (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_i     (temp_i),
        .temp_vld_i (temp_vld_i),
        .thr_cold_i (thr_cold_i),
        .thr_hot_i  (thr_hot_i),
        .band_o     (band_smp)
    );

    rs_interval_timer #(
        .HOT_CYC  (HOT_CYC),
        .NOM_CYC  (NOM_CYC),
        .COLD_CYC (COLD_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .band_next_i (band_smp),
        .tick_o      (tick),
        .band_act_o  (band_act)
    );

    rs_pending #(
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .ack_i    (ref_ack_i),
        .req_o    (ref_req_o),
        .accept_o (accept),
        .ovf_o    (ovf_o)
    );

    rs_window_cnt #(
        .WINDOW_REFS (WINDOW_REFS)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .win_done_o (win_done_o)
    );

    assign rate_o = band_act;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       ref_ack_i,
    input logic       ref_req_o,
    input logic [1:0] rate_o,
    input logic       ovf_o,
    input logic       win_done_o
);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(tick && ref_req_o)); // R8

    AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rate_o)); // R5

    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req_o) |-> $past(tick)); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_ack_i) |=> ref_req_o); // R7

    AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_o |=> !win_done_o); // R9

endmodule

bind refresh_sched refresh_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ref_ack_i  (ref_ack_i),
    .ref_req_o  (ref_req_o),
    .rate_o     (rate_o),
    .ovf_o      (ovf_o),
    .win_done_o (win_done_o)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;

    localparam int CLK_MHZ = 1;
    localparam int NOM_NS  = 8000;
    localparam int TEMP_W  = 4;
    localparam int PMAX    = 8;
    localparam int WIN     = 16;
    localparam int NOM     = CLK_MHZ * NOM_NS / 1000;
    localparam int THR_C   = 5;
    localparam int THR_H   = 11;
    localparam int LIMIT   = 100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [TEMP_W-1:0] temp = '0;
    logic              temp_vld = 1'b0;
    logic              ref_ack = 1'b0;
    logic              ref_req;
    logic [1:0]        rate;
    logic              ovf;
    logic              win_done;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  rises = 0;
    int  last_gap = 0;
    int  last_rise = 0;
    int  acc = 0;
    int  pulses = 0;
    int  manual = 0;
    bit  auto_ack = 1'b1;
    bit  spurious = 1'b0;
    bit  prev_req = 1'b0;
    bit  exp_win = 1'b0;
    bit  done = 1'b0;

    refresh_sched #(
        .CLK_MHZ     (CLK_MHZ),
        .NOM_NS      (NOM_NS),
        .TEMP_W      (TEMP_W),
        .PEND_MAX    (PMAX),
        .WINDOW_REFS (WIN)
    ) i_refresh_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_i     (temp),
        .temp_vld_i (temp_vld),
        .thr_cold_i (4'(THR_C)),
        .thr_hot_i  (4'(THR_H)),
        .ref_ack_i  (ref_ack),
        .ref_req_o  (ref_req),
        .rate_o     (rate),
        .ovf_o      (ovf),
        .win_done_o (win_done)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Acknowledge generator, request-rise tracker and window monitor.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (win_done || exp_win) begin
                chk(win_done == exp_win, "R9 window pulse", int'(win_done), int'(exp_win));
            end
            if (win_done) pulses++;
            exp_win = 1'b0;
            if (ref_req && !prev_req) begin
                rises++;
                last_gap  = cyc - last_rise;
                last_rise = cyc;
            end
            prev_req = ref_req;
            if (spurious) begin
                ref_ack  = 1'b1;
                spurious = 1'b0;
            end else if (ref_req && (auto_ack || manual > 0)) begin
                ref_ack = 1'b1;
                acc++;
                if (manual > 0) manual--;
                if (acc % WIN == 0) exp_win = 1'b1;
            end else begin
                ref_ack = 1'b0;
            end
        end
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            summary();
        end
    end

    task automatic tick_wait();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rises(input int n);
        int start;
        start = rises;
        while (rises < start + n) tick_wait();
    endtask

    function automatic int band_of(input int code);
        if (code >= THR_H) return 2;
        if (code < THR_C) return 0;
        return 1;
    endfunction

    function automatic int gap_of(input int b);
        if (b == 2) return NOM / 2;
        if (b == 0) return NOM * 2;
        return NOM;
    endfunction

    initial begin
        int prev_band;
        // R1: reset state
        repeat (3) tick_wait();
        chk(ref_req == 1'b0, "R1 req in reset", int'(ref_req), 0);
        chk(rate == 2'b10, "R1 rate in reset", int'(rate), 2);
        chk(ovf == 1'b0, "R1 ovf in reset", int'(ovf), 0);
        chk(win_done == 1'b0, "R1 win in reset", int'(win_done), 0);
        rst_n = 1'b1;
        tick_wait();
        chk(ref_req == 1'b0 && rate == 2'b10, "R1 after release", int'(ref_req), 0);

        // R2: hot spacing before any sample
        wait_rises(2);
        chk(last_gap == NOM / 2, "R2 default spacing", last_gap, NOM / 2);
        chk(rate == 2'b10, "R2 default rate", int'(rate), 2);

        // R3 R4 R5: sweep every temperature code
        prev_band = 2;
        for (int code = 0; code < (1 << TEMP_W); code++) begin
            wait_rises(1);
            temp     = 4'(code);
            temp_vld = 1'b1;
            tick_wait();
            temp_vld = 1'b0;
            temp     = 4'(15 - code);
            chk(int'(rate) == prev_band, "R5 no change mid interval", int'(rate), prev_band);
            wait_rises(3);
            chk(int'(rate) == band_of(code), "R3 band code", int'(rate), band_of(code));
            chk(last_gap == gap_of(band_of(code)), "R4 spacing", last_gap, gap_of(band_of(code)));
            prev_band = band_of(code);
        end
        chk(ovf == 1'b0, "R8 no ovf while serviced", int'(ovf), 0);

        // R6 R8: starve in the cold band
        temp     = 4'(0);
        temp_vld = 1'b1;
        tick_wait();
        temp_vld = 1'b0;
        wait_rises(3);
        auto_ack = 1'b0;
        wait_rises(1);
        for (int k = 1; k <= 128; k++) begin
            tick_wait();
            if (k == 64) chk(ref_req == 1'b1, "R6 req held while owed", int'(ref_req), 1);
            if (k == 127) chk(ovf == 1'b0, "R8 ovf before ninth expiry", int'(ovf), 0);
            if (k == 128) begin
                chk(ovf == 1'b1, "R8 ovf at ninth expiry", int'(ovf), 1);
                chk(ref_req == 1'b1, "R8 req when full", int'(ref_req), 1);
            end
        end
        manual = PMAX;
        for (int k = 129; k <= 137; k++) begin
            tick_wait();
            if (k == 136) chk(ref_req == 1'b1, "R8 one left after seven acks", int'(ref_req), 1);
            if (k == 137) chk(ref_req == 1'b0, "R8 drained after eight acks", int'(ref_req), 0);
        end

        // R7: stray acknowledge while idle
        spurious = 1'b1;
        tick_wait();
        tick_wait();
        chk(ref_req == 1'b0, "R7 stray ack keeps idle", int'(ref_req), 0);
        wait_rises(1);
        chk(ref_req == 1'b1, "R7 next expiry raises req", int'(ref_req), 1);
        manual = 1;
        tick_wait();
        tick_wait();
        chk(ref_req == 1'b0, "R7 single ack clears, no underflow", int'(ref_req), 0);
        chk(ovf == 1'b1, "R8 ovf sticky", int'(ovf), 1);

        // R9: window count over the whole run
        auto_ack = 1'b1;
        wait_rises(4);
        tick_wait();
        chk(pulses == acc / WIN, "R9 pulse total", pulses, acc / WIN);
        done = 1'b1;
        summary();
    end

endmodule